// File: doc/BRIEF.md
# Interrupt Redirection Table Register File

This block holds the routing table for a bank of interrupt inputs: one 64-bit redirection entry per input, an 8-bit identification value and a fixed version word. Software never addresses these registers directly. It first writes a selector value into an index register at one bus offset, then reads or writes the selected 32-bit register through a data window at a second offset. Each 64-bit entry takes two consecutive selector values, with the even one covering the low half and the odd one the high half. A write to either half leaves the other half as it was.

All table entries are driven out in parallel as one flat vector, so a separate dispatch block can act on them without going through the bus. Every write that lands in the table raises a one-cycle strobe, which tells that block to look at its pending inputs again under the new settings. Reset puts every entry in the masked state, so nothing is routed until software enables it.

The bus is a plain single-cycle interface. A write takes effect at the clock edge where the write enable is high. A read is captured at the edge where the read enable is high, and the data appear on the output in the following cycle.

Top module: `irq_route_regs`

## Requirements
- R1: Bus offset 0x00 is an 8-bit index register. A write stores wdata_i[7:0], and a read returns that value zero-extended to 32 bits.
- R2: Index 0x00 through the window at offset 0x10 is the identification register. A write stores wdata_i[31:24] only, and a read returns {id, 24'h000000}.
- R3: Index 0x01 reads 0x00170011, which is version 0x11 in bits 7:0 and NUM_ENT-1 in bits 23:16. Index 0x02 reads zero. Writes to either index change nothing.
- R4: Entry n (0..NUM_ENT-1) is at index 0x10+2n for bits 31:0 and at index 0x11+2n for bits 63:32. A write replaces only the addressed half, and a read returns that half.
- R5: entries_o carries entry n on bits 64n+63:64n. It shows a write from the cycle after the write edge.
- R6: After reset the index, the ID and all entry bits are zero, except bit 16 of every entry, which is one (0x0000000000010000).
- R7: tbl_wr_o is high for exactly the one cycle after each edge that performed a window write to a table index. It is low in every other cycle, including after writes to the ID, the index or an unmapped register.
- R8: With an index in 0x03..0x0F or 0x40..0xFF, a window read returns zero and a window write changes nothing.
- R9: Bus offsets other than 0x00 and 0x10 read as zero, and writes to them change nothing.
- R10: rdata_o is registered. It is loaded at an edge where rd_i is high and holds its value otherwise. A read at the same edge as a write returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write enable, single cycle |
| rd_i | input | 1 | Read enable, single cycle |
| addr_i | input | 8 | Low byte of the bus address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| entries_o | output | NUM_ENT*64 | All redirection entries in parallel |
| tbl_wr_o | output | 1 | One-cycle pulse after a table write |

## Verification
A corrupted index register sends every later window access to the wrong register. This shows up on rdata_o one cycle after the next window read, and on entries_o in the cycle after the next write. Wrong half-select or entry decode appears on entries_o in the cycle after the faulty write, as a change to a neighbouring entry or to the other half of the same entry. A bad strobe decode shows on tbl_wr_o in the cycle right after the write. Reset errors are visible on entries_o as soon as reset is released, with no bus traffic needed.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  parameter int ADDR_W   = 8;
  parameter int DATA_W   = 32;
  parameter int IDX_W    = 8;
  parameter int NUM_ENT  = 24;
  parameter int MASK_BIT = 16;

  parameter logic [ADDR_W-1:0] OFS_IDX = 8'h00;
  parameter logic [ADDR_W-1:0] OFS_WIN = 8'h10;

  parameter int IDX_ID   = 0;
  parameter int IDX_VER  = 1;
  parameter int TBL_BASE = 16;

  parameter logic [7:0] VER_CODE = 8'h11;

  typedef enum logic [2:0] {
    T_NONE,
    T_INDEX,
    T_ID,
    T_VER,
    T_TBL
  } tgt_e;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int N_ENT  = 24,
  parameter int ENT_AW = $clog2(N_ENT)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  idx_i,
  output tgt_e              tgt_o,
  output logic [ENT_AW-1:0] ent_o,
  output logic              hi_o
);
  localparam int TBL_END = TBL_BASE + 2 * N_ENT;

  logic [IDX_W-1:0] rel;
  logic             in_tbl;

  always_comb begin
    rel    = idx_i - IDX_W'(TBL_BASE);
    in_tbl = (int'(idx_i) >= TBL_BASE) && (int'(idx_i) < TBL_END);
    ent_o  = ENT_AW'(rel >> 1);
    hi_o   = rel[0];
    tgt_o  = T_NONE;
    if (addr_i == OFS_IDX) begin
      tgt_o = T_INDEX;
    end else if (addr_i == OFS_WIN) begin
      if (idx_i == IDX_W'(IDX_ID))       tgt_o = T_ID;
      else if (idx_i == IDX_W'(IDX_VER)) tgt_o = T_VER;
      else if (in_tbl)                   tgt_o = T_TBL;
    end
  end
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry #(
  parameter int                  HALF_W  = 32,
  parameter logic [2*HALF_W-1:0] RST_VAL = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [HALF_W-1:0]   wdata_i,
  output logic [2*HALF_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= RST_VAL;
    end else begin
      if (wr_lo_i) q_o[HALF_W-1:0]        <= wdata_i;
      if (wr_hi_i) q_o[2*HALF_W-1:HALF_W] <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
  import irq_route_pkg::*;
#(
  parameter int N_ENT  = 24,
  parameter int ENT_AW = $clog2(N_ENT),
  parameter int ENT_W  = 2 * DATA_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_i,
  input  tgt_e                   tgt_i,
  input  logic [ENT_AW-1:0]      ent_i,
  input  logic                   hi_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [7:0]             id_i,
  input  logic [N_ENT*ENT_W-1:0] ent_flat_i,
  output logic [DATA_W-1:0]      rdata_o
);
  localparam logic [DATA_W-1:0] VER_WORD =
    DATA_W'({8'h00, 8'(N_ENT - 1), 8'h00, VER_CODE});

  logic [ENT_W-1:0]  sel_ent;
  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    sel_ent = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (ent_i == ENT_AW'(i)) sel_ent = ent_flat_i[i*ENT_W +: ENT_W];
    end
  end

  always_comb begin
    unique case (tgt_i)
      T_INDEX: rd_nxt = DATA_W'(idx_i);
      T_ID:    rd_nxt = {id_i, {(DATA_W-8){1'b0}}};
      T_VER:   rd_nxt = VER_WORD;
      T_TBL:   rd_nxt = hi_i ? sel_ent[ENT_W-1:DATA_W] : sel_ent[DATA_W-1:0];
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_nxt;
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int N_ENT = NUM_ENT
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [N_ENT*2*DATA_W-1:0] entries_o,
  output logic                      tbl_wr_o
);
  localparam int ENT_W  = 2 * DATA_W;
  localparam int ENT_AW = $clog2(N_ENT);
  localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << MASK_BIT;

  logic [IDX_W-1:0]  idx_q;
  logic [7:0]        id_q;
  tgt_e              tgt;
  logic [ENT_AW-1:0] ent_sel;
  logic              hi_sel;
  logic              tbl_wr;

  irq_route_decode #(.N_ENT(N_ENT), .ENT_AW(ENT_AW)) u_dec (
    .addr_i (addr_i),
    .idx_i  (idx_q),
    .tgt_o  (tgt),
    .ent_o  (ent_sel),
    .hi_o   (hi_sel)
  );

  assign tbl_wr = wr_i && (tgt == T_TBL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      id_q     <= '0;
      tbl_wr_o <= 1'b0;
    end else begin
      if (wr_i && tgt == T_INDEX) idx_q <= wdata_i[IDX_W-1:0];
      if (wr_i && tgt == T_ID)    id_q  <= wdata_i[DATA_W-1 -: 8];
      tbl_wr_o <= tbl_wr;
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic hit;
    assign hit = tbl_wr && (ent_sel == ENT_AW'(g));
    irq_route_entry #(.HALF_W(DATA_W), .RST_VAL(ENT_RST)) u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_lo_i (hit && !hi_sel),
      .wr_hi_i (hit && hi_sel),
      .wdata_i (wdata_i),
      .q_o     (entries_o[g*ENT_W +: ENT_W])
    );
  end

  irq_route_rdmux #(.N_ENT(N_ENT), .ENT_AW(ENT_AW), .ENT_W(ENT_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_i),
    .tgt_i      (tgt),
    .ent_i      (ent_sel),
    .hi_i       (hi_sel),
    .idx_i      (idx_q),
    .id_i       (id_q),
    .ent_flat_i (entries_o),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk
  import irq_route_pkg::*;
#(
  parameter int N_ENT = NUM_ENT
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [IDX_W-1:0]  wlow_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              tbl_wr_o
);
  localparam int TBL_END = TBL_BASE + 2 * N_ENT;
  localparam logic [DATA_W-1:0] VER_WORD =
    DATA_W'({8'h00, 8'(N_ENT - 1), 8'h00, VER_CODE});

  logic [IDX_W-1:0] sh_idx;
  logic win_rd, win_tbl, sh_tbl, sh_unmapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sh_idx <= '0;
    else if (wr_i && addr_i == OFS_IDX) sh_idx <= wlow_i;
  end

  assign sh_tbl      = (int'(sh_idx) >= TBL_BASE) && (int'(sh_idx) < TBL_END);
  assign sh_unmapped = !sh_tbl && (int'(sh_idx) > IDX_VER);
  assign win_rd      = rd_i && (addr_i == OFS_WIN);
  assign win_tbl     = wr_i && (addr_i == OFS_WIN) && sh_tbl;

  AST_IDX_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFS_IDX) |=> rdata_o == DATA_W'($past(sh_idx))); // R1
  AST_ID_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_rd && int'(sh_idx) == IDX_ID) |=> rdata_o[23:0] == 24'h0); // R2
  AST_VER_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_rd && int'(sh_idx) == IDX_VER) |=> rdata_o == VER_WORD); // R3
  AST_STROBE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_tbl |=> tbl_wr_o); // R7
  AST_STROBE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_tbl |=> !tbl_wr_o); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_rd && sh_unmapped) |=> rdata_o == '0); // R8
  AST_OFFSET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != OFS_IDX && addr_i != OFS_WIN) |=> rdata_o == '0); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R10
endmodule

bind irq_route_regs irq_route_regs_chk #(.N_ENT(N_ENT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .addr_i   (addr_i),
  .wlow_i   (wdata_i[7:0]),
  .rdata_o  (rdata_o),
  .tbl_wr_o (tbl_wr_o)
);

// File: tb/irq_route_regs_tb.sv
module irq_route_regs_tb;
  localparam int NE  = 24;
  localparam int EW  = 64;
  localparam int NV  = 34;
  localparam logic [EW-1:0] RSTV = 64'h0000_0000_0001_0000;

  logic clk_i = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [NE*EW-1:0] entries_o;
  logic tbl_wr_o;

  int n_chk = 0, n_bad = 0;
  logic last_strb;
  logic [NE*EW-1:0] snap, exp_flat;

  always #10 clk_i = ~clk_i;

  irq_route_regs #(.N_ENT(NE)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .entries_o(entries_o), .tbl_wr_o(tbl_wr_o)
  );

  // {req[3:0], kind (1 = read and compare), addr[7:0], data or expected[31:0]}
  localparam logic [44:0] VEC [NV] = '{
    {4'd6, 1'b1, 8'h00, 32'h0000_0000},  // R6 index reset
    {4'd3, 1'b0, 8'h00, 32'h0000_0001},
    {4'd3, 1'b1, 8'h10, 32'h0017_0011},  // R3 version
    {4'd3, 1'b0, 8'h10, 32'hdead_beef},
    {4'd3, 1'b1, 8'h10, 32'h0017_0011},  // R3 write ignored
    {4'd6, 1'b0, 8'h00, 32'h0000_0000},
    {4'd6, 1'b1, 8'h10, 32'h0000_0000},  // R6 id reset
    {4'd2, 1'b0, 8'h10, 32'ha512_3456},
    {4'd2, 1'b1, 8'h10, 32'ha500_0000},  // R2 top byte only
    {4'd3, 1'b0, 8'h00, 32'h0000_0002},
    {4'd3, 1'b0, 8'h10, 32'hffff_ffff},
    {4'd3, 1'b1, 8'h10, 32'h0000_0000},  // R3 index 2 zero
    {4'd6, 1'b0, 8'h00, 32'h0000_0010},
    {4'd6, 1'b1, 8'h10, 32'h0001_0000},  // R6 mask bit
    {4'd4, 1'b0, 8'h10, 32'h0000_a031},
    {4'd4, 1'b1, 8'h10, 32'h0000_a031},  // R4 low half
    {4'd4, 1'b0, 8'h00, 32'h0000_0011},
    {4'd4, 1'b1, 8'h10, 32'h0000_0000},  // R4 high half reset
    {4'd4, 1'b0, 8'h10, 32'hff00_0000},
    {4'd4, 1'b1, 8'h10, 32'hff00_0000},  // R4 high half
    {4'd4, 1'b0, 8'h00, 32'h0000_0010},
    {4'd4, 1'b1, 8'h10, 32'h0000_a031},  // R4 low half kept
    {4'd4, 1'b0, 8'h00, 32'h0000_003f},
    {4'd4, 1'b0, 8'h10, 32'h1234_5678},
    {4'd4, 1'b1, 8'h10, 32'h1234_5678},  // R4 last entry high
    {4'd4, 1'b0, 8'h00, 32'h0000_003e},
    {4'd4, 1'b1, 8'h10, 32'h0001_0000},  // R4 last entry low kept
    {4'd8, 1'b0, 8'h00, 32'h0000_0040},
    {4'd8, 1'b1, 8'h10, 32'h0000_0000},  // R8 past table end
    {4'd1, 1'b1, 8'h00, 32'h0000_0040},  // R1 index readback
    {4'd8, 1'b0, 8'h00, 32'h0000_0007},
    {4'd8, 1'b1, 8'h10, 32'h0000_0000},  // R8 gap index
    {4'd9, 1'b1, 8'h04, 32'h0000_0000},  // R9 other offset
    {4'd9, 1'b1, 8'hff, 32'h0000_0000}   // R9 other offset
  };

  task automatic chk(input string tag, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_flat(input string tag, input logic [NE*EW-1:0] exp);
    n_chk++;
    if (entries_o !== exp) begin
      n_bad++;
      for (int i = 0; i < NE; i++)
        if (entries_o[i*EW +: EW] !== exp[i*EW +: EW])
          $display("FAIL %s entry%0d act=%h exp=%h", tag, i,
                   entries_o[i*EW +: EW], exp[i*EW +: EW]);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
    last_strb = tbl_wr_o;
  endtask

  task automatic bus_rd(input logic [7:0] a);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) exp_flat[i*EW +: EW] = RSTV;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_flat("R6 reset entries", exp_flat);
    chk("R6 reset rdata", 64'(rdata_o), 64'h0);
    chk("R7 no strobe after reset", 64'(tbl_wr_o), 64'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][40]) begin
        bus_rd(VEC[v][39:32]);
        chk($sformatf("R%0d vector %0d", VEC[v][44:41], v), 64'(rdata_o), 64'(VEC[v][31:0]));
      end else begin
        bus_wr(VEC[v][39:32], VEC[v][31:0]);
      end
    end

    // R5: parallel view after the table walk
    exp_flat[0*EW +: EW]  = 64'hff00_0000_0000_a031;
    exp_flat[23*EW +: EW] = 64'h1234_5678_0001_0000;
    chk_flat("R5 parallel entries", exp_flat);

    // R7: strobe after table write, none after ID write
    bus_wr(8'h00, 32'h0000_0015);
    chk("R7 no strobe on index write", 64'(last_strb), 64'h0);
    bus_wr(8'h10, 32'h0000_0077);
    chk("R7 strobe after table write", 64'(last_strb), 64'h1);
    exp_flat[2*EW +: EW] = 64'h0000_0077_0001_0000;
    chk_flat("R5 entry2 high visible with strobe", exp_flat);
    @(negedge clk_i);
    chk("R7 strobe one cycle only", 64'(tbl_wr_o), 64'h0);
    bus_wr(8'h00, 32'h0000_0000);
    bus_wr(8'h10, 32'h0100_0000);
    chk("R7 no strobe on ID write", 64'(last_strb), 64'h0);

    // R8: writes to unmapped indices change nothing
    snap = entries_o;
    bus_wr(8'h00, 32'h0000_0040);
    bus_wr(8'h10, 32'hffff_ffff);
    chk("R8 no strobe idx 0x40", 64'(last_strb), 64'h0);
    bus_wr(8'h00, 32'h0000_0005);
    bus_wr(8'h10, 32'hffff_ffff);
    chk_flat("R8 entries unchanged", snap);

    // R9: write to other offset leaves index and table alone
    bus_wr(8'h20, 32'h0000_0012);
    chk("R9 no strobe other offset", 64'(last_strb), 64'h0);
    bus_rd(8'h00);
    chk("R9 index unchanged", 64'(rdata_o), 64'h5);
    chk_flat("R9 entries unchanged", snap);

    // R10: read at the same edge as a write sees old data, then holds
    bus_wr(8'h00, 32'h0000_0012);
    @(negedge clk_i);
    wr_i = 1'b1; rd_i = 1'b1; addr_i = 8'h10; wdata_i = 32'h0000_0042;
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0;
    chk("R10 read before write", 64'(rdata_o), 64'h0001_0000);
    exp_flat[1*EW +: EW] = 64'h0000_0000_0000_0042;
    chk_flat("R4 entry1 low replaced mask cleared", exp_flat);
    repeat (3) @(negedge clk_i);
    chk("R10 rdata held", 64'(rdata_o), 64'h0001_0000);
    bus_rd(8'h10);
    chk("R10 new data after read", 64'(rdata_o), 64'h42);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule